// File: doc/BRIEF.md
# NAND Flash Control-Word Sequencer

This block drives the pins of an 8-bit NAND flash device from one 32-bit control word. Software first loads the column, row, data, address-size and timing registers over a plain register port. It then writes a control word whose bits choose the phases to run: an opening command byte, address cycles, a closing command byte with a wait for the device to become ready, and a data transfer of one to four bytes. The start bit reads back as set until the whole word has finished.

Whatever phases are enabled always run in one fixed order. Each bus cycle has a setup time, a strobe time and a hold time, each taken in clock cycles from a packed timing register. A chip-select-hold bit keeps CE# low after the word ends, so that a page read or write can be built from several words with CE# held low the whole time. Clearing that bit in the last word releases the device.

Top module: `nand_word_seq`

## Requirements
- R1: After reset, CE#, WE# and RE# are high, CLE, ALE and the bus output enable are low, and control bit 31 reads 0.
- R2: A control write with bit 31 set starts a word. Control bit 31 reads 1 from the next cycle until the word finishes, and then reads 0.
- R3: Enabled phases run in this order: command byte bits 7:0 (enable bit 16), address cycles, command byte bits 15:8 (enable bit 19), then data. Command bytes are latched on the WE# rising edge with CLE high and ALE low.
- R4: Bit 17 sends (config bits 5:4)+1 column bytes taken from the column register. Bit 18 then sends (config bits 7:6)+1 row bytes taken from the row register. Each group goes least significant byte first, with ALE high.
- R5: Bit 24 replaces all column and row cycles with one address cycle of 0x00, whatever bits 17 and 18 hold.
- R6: Bit 20 reads (bits 29:28)+1 bytes on RE# strobes into the data register. Byte k lands in bits 8k+7:8k, and the bytes not read become zero.
- R7: Bit 21 (when bit 20 is clear) writes (bits 29:28)+1 bytes from the data register, lowest byte first, with CLE and ALE low.
- R8: CE# is low during every strobe. When a word ends, CE# stays low if bit 30 was set and goes high if bit 30 was clear.
- R9: While a word runs, every register write is ignored, including a second start.
- R10: After the closing command, the block waits the count in timing bits 29:24 and then for R/B# high. If R/B# stays low past the timeout register count, control bit 27 is set and the data phase is skipped. Bit 27 clears at the next start.
- R11: Control bit 26 follows the R/B# pin after a two-flop synchronizer.
- R12: WE# or RE# stays low for max(timing bits 11:6, 1) cycles. Setup and hold use bits 5:0 and 17:12, and the turnaround before data uses bits 23:18.
- R13: CLE and ALE are never high together, WE# and RE# are never low together, and the bus is not driven while RE# is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 control, 1 column, 2 row, 3 data, 4 config, 5 timing, 6 timeout |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Byte driven onto the I/O bus |
| nand_io_oe | output | 1 | Output enable for the I/O bus |
| nand_io_in | input | 8 | Byte sampled from the I/O bus |
| nand_rb_n | input | 1 | Ready/busy pin, low while the device is busy |

## Verification
The bench sends words that enable different subsets of phases. The subsets are a command alone, a command with column and row bytes and a closing command, a special single address cycle, a four-byte read, a single-byte read, and a three-byte write. Comparing the captured bus trace with each expected sequence separates ordering faults, byte-order faults and faults in the count fields. Holding R/B# low exposes the timeout and the skipped data phase. Releasing R/B# partway through a wait shows that the block waits rather than giving up early. A second start issued mid-word, together with the chip-select-hold bit seen across a burst, checks how busy state and CE# behave at word boundaries.

// File: rtl/nseq_pkg.sv
`timescale 1ns/1ps
package nseq_pkg;
   localparam int WC_W = 6;

   localparam logic [2:0] RA_CTRL = 3'd0;
   localparam logic [2:0] RA_COL  = 3'd1;
   localparam logic [2:0] RA_ROW  = 3'd2;
   localparam logic [2:0] RA_DATA = 3'd3;
   localparam logic [2:0] RA_CFG  = 3'd4;
   localparam logic [2:0] RA_WAIT = 3'd5;
   localparam logic [2:0] RA_TMO  = 3'd6;

   localparam int B_START = 31;
   localparam int B_HOLD  = 30;
   localparam int B_ERR   = 27;
   localparam int B_RDY   = 26;
   localparam int B_SPEC  = 24;
   localparam int B_WR    = 21;
   localparam int B_RD    = 20;
   localparam int B_CMD2  = 19;
   localparam int B_ROW   = 18;
   localparam int B_COL   = 17;
   localparam int B_CMD1  = 16;

   typedef enum logic [1:0] {BK_CMD, BK_ADDR, BK_WR, BK_RD} bus_kind_e;

   typedef enum logic [2:0] {
      PH_IDLE, PH_CMD1, PH_ADDR, PH_CMD2, PH_RDLY, PH_RWAIT, PH_GAP, PH_DATA
   } phase_e;

   typedef struct packed {
      logic [WC_W-1:0] rwait;
      logic [WC_W-1:0] gap;
      logic [WC_W-1:0] hold;
      logic [WC_W-1:0] strobe;
      logic [WC_W-1:0] setup;
   } wait_t;

   function automatic logic [WC_W-1:0] wc_load(input logic [WC_W-1:0] v);
      return (v == '0) ? '0 : v - 1'b1;
   endfunction
endpackage

// File: rtl/nseq_bus.sv
`timescale 1ns/1ps
module nseq_bus
   import nseq_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  bus_kind_e       kind,
   input  logic [7:0]      tx_byte,
   input  logic [WC_W-1:0] t_setup,
   input  logic [WC_W-1:0] t_strobe,
   input  logic [WC_W-1:0] t_hold,
   input  logic [7:0]      io_in,
   output logic            cle,
   output logic            ale,
   output logic            we_n,
   output logic            re_n,
   output logic            io_oe,
   output logic [7:0]      io_out,
   output logic            done,
   output logic            cap,
   output logic [7:0]      cap_byte
);
   typedef enum logic [1:0] {BS_IDLE, BS_SETUP, BS_STROBE, BS_HOLD} bstate_e;

   bstate_e         st;
   bus_kind_e       kd;
   logic [WC_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= BS_IDLE;
         kd       <= BK_CMD;
         cnt      <= '0;
         io_out   <= '0;
         done     <= 1'b0;
         cap      <= 1'b0;
         cap_byte <= '0;
      end else begin
         done <= 1'b0;
         cap  <= 1'b0;
         case (st)
            BS_IDLE: if (go) begin
               st     <= BS_SETUP;
               kd     <= kind;
               io_out <= (kind == BK_RD) ? 8'h00 : tx_byte;
               cnt    <= wc_load(t_setup);
            end
            BS_SETUP: if (cnt == '0) begin
               st  <= BS_STROBE;
               cnt <= wc_load(t_strobe);
            end else cnt <= cnt - 1'b1;
            BS_STROBE: if (cnt == '0) begin
               st  <= BS_HOLD;
               cnt <= wc_load(t_hold);
               if (kd == BK_RD) begin
                  cap      <= 1'b1;
                  cap_byte <= io_in;
               end
            end else cnt <= cnt - 1'b1;
            BS_HOLD: if (cnt == '0) begin
               st   <= BS_IDLE;
               done <= 1'b1;
            end else cnt <= cnt - 1'b1;
            default: st <= BS_IDLE;
         endcase
      end
   end

   always_comb begin
      cle   = (st != BS_IDLE) && (kd == BK_CMD);
      ale   = (st != BS_IDLE) && (kd == BK_ADDR);
      io_oe = (st != BS_IDLE) && (kd != BK_RD);
      we_n  = !((st == BS_STROBE) && (kd != BK_RD));
      re_n  = !((st == BS_STROBE) && (kd == BK_RD));
   end
endmodule

// File: rtl/nseq_ctl.sv
`timescale 1ns/1ps
module nseq_ctl
   import nseq_pkg::*;
#(
   parameter int TO_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [31:0]     word_in,
   input  logic [31:0]     col,
   input  logic [31:0]     row,
   input  logic [31:0]     data_q,
   input  logic [1:0]      col_n,
   input  logic [1:0]      row_n,
   input  wait_t           wt,
   input  logic [TO_W-1:0] tmo,
   input  logic            rb_ready,
   input  logic            bus_done,
   input  logic            bus_cap,
   output logic            bus_go,
   output bus_kind_e       bus_kind,
   output logic [7:0]      bus_byte,
   output logic            busy,
   output logic            err,
   output logic            ce_n,
   output logic [31:0]     cw,
   output logic            dat_clr,
   output logic            dat_we,
   output logic [1:0]      dat_lane
);
   phase_e          ph, nx;
   logic            issued, adv, tmo_hit;
   logic [3:0]      idx, n_col, n_row, n_addr, n_data, a_off;
   logic [TO_W-1:0] tcnt;
   logic [WC_W-1:0] dcnt;
   logic            rd_en;
   logic [7:0]      addr_byte;

   function automatic phase_e next_ph(input logic [31:0] w, input phase_e cur);
      logic a_en, d_en;
      a_en = w[B_SPEC] | w[B_COL] | w[B_ROW];
      d_en = w[B_RD] | w[B_WR];
      if (cur == PH_RDLY) return PH_RWAIT;
      if (cur == PH_GAP)  return PH_DATA;
      if (cur == PH_DATA) return PH_IDLE;
      if (cur == PH_CMD2) return PH_RDLY;
      if (cur == PH_IDLE && w[B_CMD1]) return PH_CMD1;
      if ((cur == PH_IDLE || cur == PH_CMD1) && a_en) return PH_ADDR;
      if (cur != PH_RWAIT && w[B_CMD2]) return PH_CMD2;
      if (d_en) return PH_GAP;
      return PH_IDLE;
   endfunction

   assign busy     = (ph != PH_IDLE);
   assign rd_en    = cw[B_RD];
   assign n_col    = cw[B_COL] ? {2'b00, col_n} + 4'd1 : 4'd0;
   assign n_row    = cw[B_ROW] ? {2'b00, row_n} + 4'd1 : 4'd0;
   assign n_addr   = cw[B_SPEC] ? 4'd1 : n_col + n_row;
   assign n_data   = {2'b00, cw[29:28]} + 4'd1;
   assign a_off    = idx - n_col;
   assign dat_we   = bus_cap && (ph == PH_DATA);
   assign dat_lane = idx[1:0];

   always_comb begin
      if (cw[B_SPEC])     addr_byte = 8'h00;
      else if (idx < n_col) addr_byte = col[{idx[1:0], 3'b000} +: 8];
      else                addr_byte = row[{a_off[1:0], 3'b000} +: 8];
   end

   always_comb begin
      nx       = next_ph(cw, ph);
      adv      = 1'b0;
      tmo_hit  = 1'b0;
      bus_go   = 1'b0;
      bus_kind = BK_CMD;
      bus_byte = 8'h00;
      case (ph)
         PH_CMD1: begin
            bus_go = !issued; bus_byte = cw[7:0]; adv = bus_done;
         end
         PH_ADDR: begin
            bus_go = !issued; bus_kind = BK_ADDR; bus_byte = addr_byte;
            adv = bus_done && (idx == n_addr - 4'd1);
         end
         PH_CMD2: begin
            bus_go = !issued; bus_byte = cw[15:8]; adv = bus_done;
         end
         PH_RDLY, PH_GAP: adv = (dcnt == '0);
         PH_RWAIT: begin
            if (rb_ready) adv = 1'b1;
            else if (tcnt == tmo) begin
               adv = 1'b1; tmo_hit = 1'b1; nx = PH_IDLE;
            end
         end
         PH_DATA: begin
            bus_go   = !issued;
            bus_kind = rd_en ? BK_RD : BK_WR;
            bus_byte = data_q[{idx[1:0], 3'b000} +: 8];
            adv      = bus_done && (idx == n_data - 4'd1);
         end
         default: ;
      endcase
      dat_clr = adv && (nx == PH_DATA) && rd_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= PH_IDLE;
         cw     <= '0;
         issued <= 1'b0;
         idx    <= '0;
         dcnt   <= '0;
         tcnt   <= '0;
         err    <= 1'b0;
         ce_n   <= 1'b1;
      end else begin
         if (bus_go) issued <= 1'b1;
         if (ph == PH_IDLE) begin
            if (start) begin
               cw     <= word_in & ~32'h8C00_0000;
               err    <= 1'b0;
               ph     <= next_ph(word_in, PH_IDLE);
               issued <= 1'b0;
               idx    <= '0;
               dcnt   <= wc_load(wt.gap);
               ce_n   <= (next_ph(word_in, PH_IDLE) == PH_IDLE) ? ~word_in[B_HOLD] : 1'b0;
            end
         end else if (adv) begin
            ph     <= nx;
            issued <= 1'b0;
            idx    <= '0;
            tcnt   <= '0;
            dcnt   <= wc_load((nx == PH_RDLY) ? wt.rwait : wt.gap);
            if (tmo_hit) err <= 1'b1;
            if (nx == PH_IDLE) ce_n <= ~cw[B_HOLD];
         end else begin
            if (bus_done) begin
               idx    <= idx + 4'd1;
               issued <= 1'b0;
            end
            if (ph == PH_RDLY || ph == PH_GAP) dcnt <= dcnt - 1'b1;
            if (ph == PH_RWAIT) tcnt <= tcnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/nand_word_seq.sv
`timescale 1ns/1ps
module nand_word_seq
   import nseq_pkg::*;
#(
   parameter int TO_W        = 16,
   parameter int SYNC_STAGES = 2,
   parameter int TMO_RESET   = 1000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        nand_ce_n,
   output logic        nand_cle,
   output logic        nand_ale,
   output logic        nand_we_n,
   output logic        nand_re_n,
   output logic [7:0]  nand_io_out,
   output logic        nand_io_oe,
   input  logic [7:0]  nand_io_in,
   input  logic        nand_rb_n
);
   localparam logic [TO_W-1:0] TMO_INIT = TMO_RESET[TO_W-1:0];

   initial begin
      if (TO_W < 4 || TO_W > 32) $fatal(1, "TO_W out of range");
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) $fatal(1, "SYNC_STAGES out of range");
   end

   logic [31:0]     col_q, row_q, data_q, cw;
   logic [3:0]      cfg_q;
   wait_t           wt_q;
   logic [TO_W-1:0] tmo_q;
   logic            busy, err, rb_ready, start, wr_ok;
   logic            bus_go, bus_done, bus_cap;
   bus_kind_e       bus_kind;
   logic [7:0]      bus_byte, cap_byte;
   logic            dat_clr, dat_we;
   logic [1:0]      dat_lane;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         logic q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q <= 1'b1; else q <= nand_rb_n;
         assign rb_ready = q;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sr <= '1; else sr <= {sr[SYNC_STAGES-2:0], nand_rb_n};
         assign rb_ready = sr[SYNC_STAGES-1];
      end
   endgenerate

   assign wr_ok = reg_wr && !busy;
   assign start = wr_ok && (reg_addr == RA_CTRL) && reg_wdata[B_START];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q  <= '0;
         row_q  <= '0;
         data_q <= '0;
         cfg_q  <= '0;
         wt_q   <= '0;
         tmo_q  <= TMO_INIT;
      end else begin
         if (dat_clr) data_q <= '0;
         else if (dat_we) data_q[{dat_lane, 3'b000} +: 8] <= cap_byte;
         else if (wr_ok && reg_addr == RA_DATA) data_q <= reg_wdata;
         if (wr_ok) begin
            case (reg_addr)
               RA_COL:  col_q <= reg_wdata;
               RA_ROW:  row_q <= reg_wdata;
               RA_CFG:  cfg_q <= reg_wdata[7:4];
               RA_WAIT: wt_q  <= reg_wdata[29:0];
               RA_TMO:  tmo_q <= reg_wdata[TO_W-1:0];
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (reg_addr)
         RA_CTRL: reg_rdata = cw | ({31'b0, busy} << B_START) | ({31'b0, err} << B_ERR)
                              | ({31'b0, rb_ready} << B_RDY);
         RA_COL:  reg_rdata = col_q;
         RA_ROW:  reg_rdata = row_q;
         RA_DATA: reg_rdata = data_q;
         RA_CFG:  reg_rdata = {24'b0, cfg_q, 4'b0};
         RA_WAIT: reg_rdata = {2'b0, wt_q};
         RA_TMO:  reg_rdata = 32'(tmo_q);
         default: reg_rdata = '0;
      endcase
   end

   nseq_ctl #(.TO_W(TO_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .start(start), .word_in(reg_wdata),
      .col(col_q), .row(row_q), .data_q(data_q),
      .col_n(cfg_q[1:0]), .row_n(cfg_q[3:2]), .wt(wt_q), .tmo(tmo_q),
      .rb_ready(rb_ready), .bus_done(bus_done), .bus_cap(bus_cap),
      .bus_go(bus_go), .bus_kind(bus_kind), .bus_byte(bus_byte),
      .busy(busy), .err(err), .ce_n(nand_ce_n), .cw(cw),
      .dat_clr(dat_clr), .dat_we(dat_we), .dat_lane(dat_lane)
   );

   nseq_bus u_bus (
      .clk(clk), .rst_n(rst_n), .go(bus_go), .kind(bus_kind), .tx_byte(bus_byte),
      .t_setup(wt_q.setup), .t_strobe(wt_q.strobe), .t_hold(wt_q.hold),
      .io_in(nand_io_in), .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n),
      .re_n(nand_re_n), .io_oe(nand_io_oe), .io_out(nand_io_out),
      .done(bus_done), .cap(bus_cap), .cap_byte(cap_byte)
   );
endmodule

// File: rtl/nseq_checker.sv
`timescale 1ns/1ps
module nseq_checker (
   input logic clk,
   input logic rst_n,
   input logic ce_n,
   input logic cle,
   input logic ale,
   input logic we_n,
   input logic re_n,
   input logic io_oe,
   input logic busy
);
   a_r13_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale));
   a_r13_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !re_n));
   a_r13_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      !re_n |-> !io_oe);
   a_r7_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> io_oe);
   a_r8_ce_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n || !re_n) |-> !ce_n);
   a_r2_strobe_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n || !re_n) |-> busy);
endmodule

bind nand_word_seq nseq_checker u_nseq_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(nand_ce_n), .cle(nand_cle), .ale(nand_ale),
   .we_n(nand_we_n), .re_n(nand_re_n), .io_oe(nand_io_oe), .busy(busy)
);

// File: tb/nand_word_seq_bench.sv
`timescale 1ns/1ps
module nand_word_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = 32'd0;
   logic [31:0] reg_rdata;
   logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
   logic [7:0]  nand_io_out;
   logic [7:0]  nand_io_in = 8'h00;
   logic        nand_rb_n = 1'b1;

   int n_chk = 0;
   int n_fail = 0;
   int n_ev = 0;
   int n_rd = 0;
   int rd_idx = 0;
   int we_w = 0;
   int last_we_w = 0;
   int ev_kind [32];
   logic [7:0] ev_byte [32];
   logic [7:0] rd_src [4];
   logic prev_we = 1'b1;
   logic prev_re = 1'b1;

   always #10 clk = ~clk;

   nand_word_seq u_nand_word_seq (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nand_ce_n(nand_ce_n),
      .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
      .nand_re_n(nand_re_n), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
      .nand_io_in(nand_io_in), .nand_rb_n(nand_rb_n)
   );

   // bus monitor and device model, sampled away from the active edge
   always @(negedge clk) begin
      if (!nand_we_n) we_w = we_w + 1;
      if (nand_we_n && !prev_we) begin
         if (n_ev < 32) begin
            ev_kind[n_ev] = nand_cle ? 0 : (nand_ale ? 1 : 2);
            ev_byte[n_ev] = nand_io_out;
         end
         n_ev = n_ev + 1;
         last_we_w = we_w;
         we_w = 0;
      end
      if (!nand_re_n) nand_io_in = rd_src[rd_idx % 4];
      if (nand_re_n && !prev_re) begin
         rd_idx = rd_idx + 1;
         n_rd = n_rd + 1;
      end
      prev_we = nand_we_n;
      prev_re = nand_re_n;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic write_reg(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic read_reg(input logic [2:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int i = 0; i < 5000; i++) begin
         read_reg(3'd0, s);
         if (!s[31]) return;
      end
      check("R2 word never finished", 32'd1, 32'd0);
   endtask

   task automatic clear_trace();
      n_ev = 0; n_rd = 0; rd_idx = 0;
   endtask

   task automatic expect_ev(input string req, input int i, input int k, input logic [7:0] b);
      check(req, 32'(ev_kind[i]), 32'(k));
      check(req, {24'b0, ev_byte[i]}, {24'b0, b});
   endtask

   task automatic t_reset();
      logic [31:0] s;
      read_reg(3'd0, s);
      check("R1 ce_n", {31'b0, nand_ce_n}, 32'd1);
      check("R1 cle/ale", {30'b0, nand_cle, nand_ale}, 32'd0);
      check("R1 we_n/re_n", {30'b0, nand_we_n, nand_re_n}, 32'd3);
      check("R1 io_oe", {31'b0, nand_io_oe}, 32'd0);
      check("R1 start bit", {31'b0, s[31]}, 32'd0);
   endtask

   task automatic t_cmd_only();
      logic [31:0] s;
      clear_trace();
      write_reg(3'd0, 32'h8001_00FF);
      read_reg(3'd0, s);
      check("R2 busy after start", {31'b0, s[31]}, 32'd1);
      wait_idle();
      read_reg(3'd0, s);
      check("R2 done clears start", {31'b0, s[31]}, 32'd0);
      check("R3 cmd-only count", 32'(n_ev), 32'd1);
      expect_ev("R3 cmd-only byte", 0, 0, 8'hFF);
      check("R8 ce released", {31'b0, nand_ce_n}, 32'd1);
   endtask

   task automatic t_addr_read_start();
      logic [31:0] s;
      write_reg(3'd4, 32'h0000_0090);
      write_reg(3'd1, 32'h0000_1234);
      write_reg(3'd2, 32'h0056_789A);
      clear_trace();
      write_reg(3'd0, 32'hC00F_3000);
      wait_idle();
      check("R3 R4 event count", 32'(n_ev), 32'd7);
      expect_ev("R3 cmd1", 0, 0, 8'h00);
      expect_ev("R4 col0", 1, 1, 8'h34);
      expect_ev("R4 col1", 2, 1, 8'h12);
      expect_ev("R4 row0", 3, 1, 8'h9A);
      expect_ev("R4 row1", 4, 1, 8'h78);
      expect_ev("R4 row2", 5, 1, 8'h56);
      expect_ev("R3 cmd2", 6, 0, 8'h30);
      check("R8 ce held", {31'b0, nand_ce_n}, 32'd0);
      read_reg(3'd0, s);
      check("R10 no error when ready", {31'b0, s[27]}, 32'd0);
   endtask

   task automatic t_read4();
      logic [31:0] d;
      rd_src[0] = 8'h11; rd_src[1] = 8'h22; rd_src[2] = 8'h33; rd_src[3] = 8'h44;
      clear_trace();
      write_reg(3'd0, 32'hB010_0000);
      wait_idle();
      read_reg(3'd3, d);
      check("R6 four-byte read", d, 32'h4433_2211);
      check("R6 read strobes", 32'(n_rd), 32'd4);
      check("R8 burst end releases ce", {31'b0, nand_ce_n}, 32'd1);
   endtask

   task automatic t_read1();
      logic [31:0] d;
      write_reg(3'd3, 32'hFFFF_FFFF);
      rd_src[0] = 8'hAB;
      clear_trace();
      write_reg(3'd0, 32'h8010_0000);
      wait_idle();
      read_reg(3'd3, d);
      check("R6 single byte zero-fills", d, 32'h0000_00AB);
   endtask

   task automatic t_special();
      clear_trace();
      write_reg(3'd0, 32'h8107_0090);
      wait_idle();
      check("R5 event count", 32'(n_ev), 32'd2);
      expect_ev("R5 cmd", 0, 0, 8'h90);
      expect_ev("R5 single zero addr", 1, 1, 8'h00);
   endtask

   task automatic t_write();
      write_reg(3'd3, 32'hDDCC_BBAA);
      clear_trace();
      write_reg(3'd0, 32'hA020_0000);
      wait_idle();
      check("R7 write count", 32'(n_ev), 32'd3);
      expect_ev("R7 byte0", 0, 2, 8'hAA);
      expect_ev("R7 byte1", 1, 2, 8'hBB);
      expect_ev("R7 byte2", 2, 2, 8'hCC);
      check("R7 no read strobe", 32'(n_rd), 32'd0);
      check("R12 strobe width 2", 32'(last_we_w), 32'd2);
      write_reg(3'd5, (32'd2 << 24) | (32'd1 << 18) | (32'd1 << 12) | (32'd5 << 6) | 32'd1);
      clear_trace();
      write_reg(3'd0, 32'h8001_0070);
      wait_idle();
      check("R12 strobe width 5", 32'(last_we_w), 32'd5);
   endtask

   task automatic t_busy_ignore();
      logic [31:0] v;
      write_reg(3'd3, 32'h0102_0304);
      clear_trace();
      write_reg(3'd0, 32'hB020_0000);
      write_reg(3'd0, 32'h8001_0055);
      write_reg(3'd1, 32'h0000_FFFF);
      wait_idle();
      check("R9 second start ignored", 32'(n_ev), 32'd4);
      expect_ev("R9 last byte from first word", 3, 2, 8'h01);
      read_reg(3'd1, v);
      check("R9 column write ignored", v, 32'h0000_1234);
   endtask

   task automatic t_timeout();
      logic [31:0] s;
      write_reg(3'd6, 32'd20);
      nand_rb_n = 1'b0;
      clear_trace();
      write_reg(3'd0, 32'h8019_1080);
      wait_idle();
      read_reg(3'd0, s);
      check("R10 error flag", {31'b0, s[27]}, 32'd1);
      check("R10 data skipped", 32'(n_rd), 32'd0);
      check("R10 cmds sent", 32'(n_ev), 32'd2);
      nand_rb_n = 1'b1;
      repeat (4) @(negedge clk);
      write_reg(3'd0, 32'h8001_00FF);
      wait_idle();
      read_reg(3'd0, s);
      check("R10 error cleared by start", {31'b0, s[27]}, 32'd0);
   endtask

   task automatic t_ready_mirror();
      logic [31:0] s;
      nand_rb_n = 1'b0;
      repeat (4) @(negedge clk);
      read_reg(3'd0, s);
      check("R11 ready low", {31'b0, s[26]}, 32'd0);
      nand_rb_n = 1'b1;
      repeat (4) @(negedge clk);
      read_reg(3'd0, s);
      check("R11 ready high", {31'b0, s[26]}, 32'd1);
   endtask

   task automatic t_ready_wait();
      logic [31:0] s;
      logic [31:0] d;
      write_reg(3'd6, 32'd200);
      nand_rb_n = 1'b0;
      rd_src[0] = 8'h5A;
      clear_trace();
      write_reg(3'd0, 32'h8018_3000);
      repeat (25) @(negedge clk);
      read_reg(3'd0, s);
      check("R10 waits for ready", {31'b0, s[31]}, 32'd1);
      check("R10 no read before ready", 32'(n_rd), 32'd0);
      nand_rb_n = 1'b1;
      wait_idle();
      read_reg(3'd0, s);
      check("R10 no error after late ready", {31'b0, s[27]}, 32'd0);
      read_reg(3'd3, d);
      check("R10 data after ready", d, 32'h0000_005A);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      write_reg(3'd5, (32'd2 << 24) | (32'd1 << 18) | (32'd1 << 12) | (32'd2 << 6) | 32'd1);
      t_cmd_only();
      t_addr_read_start();
      t_read4();
      t_read1();
      t_special();
      t_write();
      t_busy_ignore();
      t_timeout();
      t_ready_mirror();
      t_ready_wait();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule